// File: doc/BRIEF.md
# Serial Port Idle-Mode Wake Controller

This block governs the two power modes of a four-channel serial clock/data port of the PS/2 kind. In Active mode, firmware may rewrite the output-signal register that drives the channel pins, and the shift engine may run. When firmware asks for Idle mode, the block freezes that register and stops the shift engine. It then watches the clock and data inputs of every channel for a falling edge, which marks the start bit of a frame.

A channel can wake the system only if two conditions hold. Its clock release bit in the output-signal register must be 1, and that bit is held unchanged for the whole Idle period. The line that falls must also have its wake enable set. On a qualifying edge, the block returns to Active, pulses a wake event and records which channels caused the wake. The source record stays set until firmware clears it.

A request for Idle is refused while the shift engine is enabled. A refusal sets a sticky error flag. Cancelling the half-received frame after a wake, and decoding frames, are left to other logic.

Top module: `ser_idle_wake`

## Requirements
- R1: After reset the block is Active (`isIdle`=0), `outSig` is all ones, and `wakePulse`, `wakeSrc` and `idleErr` are 0.
- R2: `idleReq` sampled high while Active with `shiftEn` low makes `isIdle` 1 from the next cycle. `idleReq` has no effect while Idle.
- R3: `idleReq` sampled high while Active with `shiftEn` high leaves the block Active and sets `idleErr`. `idleErr` stays 1 until `flagClr` is sampled high.
- R4: In Active mode, `wrEn` loads `wrData` into `outSig` on the next cycle. In Idle mode, `wrEn` has no effect and `outSig` holds. Bit i of the register is the clock release bit of channel i, and bit NCH+i is the data bit of channel i.
- R5: `shiftRun` equals `shiftEn` while Active and is 0 while Idle.
- R6: A channel whose clock release bit (`outSig` bit i) is 0 never causes a wake.
- R7: While Idle, a falling edge causes a wake in two cases: on `clkIn[i]` when `clkWakeEn[i]` is 1, or on `datIn[i]` when `datWakeEn[i]` is 1. Rising edges, and falling edges on lines whose enable is 0, cause no wake.
- R8: `isIdle` returns to 0, and `wakePulse` is 1 for exactly one cycle, at the third rising clock edge after the qualifying input change. The first two edges are the synchronizer; the third registers the wake.
- R9: An edge that reaches the edge detector during the first cycle of Idle is ignored.
- R10: On a wake, `wakeSrc` bit i is set for every channel with a qualifying edge in that cycle. Bits accumulate and hold until `flagClr`. If a wake and `flagClr` fall in the same cycle, the new bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | 1 | Request to enter Idle mode |
| shiftEn | input | 1 | Shift engine enabled by firmware |
| wrEn | input | 1 | Write strobe for the output-signal register |
| wrData | input | 2*NCH | Write data: clock bits [NCH-1:0], data bits [2*NCH-1:NCH] |
| clkIn | input | NCH | Asynchronous channel clock lines |
| datIn | input | NCH | Asynchronous channel data lines |
| clkWakeEn | input | NCH | Falling-edge wake enable per clock line |
| datWakeEn | input | NCH | Falling-edge wake enable per data line |
| flagClr | input | 1 | Clears `wakeSrc` and `idleErr` |
| isIdle | output | 1 | Current mode, 1 = Idle |
| shiftRun | output | 1 | Shift engine permitted to run |
| outSig | output | 2*NCH | Output-signal register |
| wakePulse | output | 1 | One-cycle wake event |
| wakeSrc | output | NCH | Latched wake-source channels |
| idleErr | output | 1 | Sticky flag: Idle refused because the shift engine was on |

## Verification
Directed sequences give each of the following a case of its own: a falling clock edge on a disarmed channel, a rising edge, a data edge with its enable off, and an edge timed to land in the masked first Idle cycle. These separate the arming, polarity, enable and masking conditions from one another. Two wakes in a row, first from a clock line and then from a data line, show that the source record accumulates. They also place the wake in the exact cycle, so an extra or a missing synchronizer stage shows up. A constrained-random phase follows, with sparse line toggles, random write data, refused and accepted Idle requests, and clears. It compares every output in every cycle against a bench model of the mode, arming and source rules, which exposes interactions such as a clear that coincides with a wake.

// File: rtl/ser_wake_pkg.sv
package ser_wake_pkg;
  typedef enum logic [1:0] {
    ST_ACT   = 2'd0,
    ST_IDLE0 = 2'd1,
    ST_IDLE  = 2'd2
  } mode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;       // writes frozen
    logic watch;      // edges may wake
    logic leaveIdle;  // wake taken this cycle
  } ctl_t;
endpackage

// File: rtl/ser_wake_sync.sv
module ser_wake_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage1;

  // lines rest high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '1;
      sync   <= '1;
      prev   <= '1;
    end else begin
      stage1 <= din;
      sync   <= stage1;
      prev   <= sync;
    end
  end
endmodule

// File: rtl/ser_wake_dp.sv
module ser_wake_dp
  import ser_wake_pkg::*;
#(
  parameter int NCH = 4,
  localparam int RW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctl_t           ctl,
  input  logic           wrEn,
  input  logic [RW-1:0]  wrData,
  input  logic [NCH-1:0] clkIn,
  input  logic [NCH-1:0] datIn,
  input  logic [NCH-1:0] clkWakeEn,
  input  logic [NCH-1:0] datWakeEn,
  input  logic           flagClr,
  output logic [RW-1:0]  outSig,
  output logic [NCH-1:0] wakeSrc,
  output logic           anyHit
);
  logic [NCH-1:0] syncC, prevC, syncD, prevD;
  logic [NCH-1:0] fallC, fallD, armed, hitVec;

  ser_wake_sync #(.W(NCH)) uSyncClk (
    .clk(clk), .rstN(rstN), .din(clkIn), .sync(syncC), .prev(prevC)
  );
  ser_wake_sync #(.W(NCH)) uSyncDat (
    .clk(clk), .rstN(rstN), .din(datIn), .sync(syncD), .prev(prevD)
  );

  assign armed = outSig[NCH-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign fallC[i]  = prevC[i] & ~syncC[i];
    assign fallD[i]  = prevD[i] & ~syncD[i];
    assign hitVec[i] = ctl.watch & armed[i] &
                       ((fallC[i] & clkWakeEn[i]) | (fallD[i] & datWakeEn[i]));
  end

  assign anyHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSig <= '1;
    end else if (wrEn && !ctl.idle) begin
      outSig <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeSrc <= '0;
    end else begin
      wakeSrc <= (flagClr ? '0 : wakeSrc) | (ctl.leaveIdle ? hitVec : '0);
    end
  end

  // R4: register frozen for the whole Idle period
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.idle) && ctl.idle) |-> $stable(outSig));

  // R10: without a clear no source bit is ever lost
  p_src_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !flagClr |=> ((wakeSrc & $past(wakeSrc)) == $past(wakeSrc)));
endmodule

// File: rtl/ser_wake_ctrl.sv
module ser_wake_ctrl
  import ser_wake_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic idleReq,
  input  logic shiftEn,
  input  logic flagClr,
  input  logic anyHit,
  output ctl_t ctl,
  output logic isIdle,
  output logic shiftRun,
  output logic wakePulse,
  output logic idleErr
);
  mode_t state, stateNx;
  logic  refuse;

  assign refuse = (state == ST_ACT) && idleReq && shiftEn;

  always_comb begin
    stateNx = state;
    unique case (state)
      ST_ACT:   if (idleReq && !shiftEn) stateNx = ST_IDLE0;
      ST_IDLE0: stateNx = ST_IDLE;
      ST_IDLE:  if (anyHit) stateNx = ST_ACT;
      default:  stateNx = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ACT;
      wakePulse <= 1'b0;
      idleErr   <= 1'b0;
    end else begin
      state     <= stateNx;
      wakePulse <= (state == ST_IDLE) && anyHit;
      if (refuse)       idleErr <= 1'b1;
      else if (flagClr) idleErr <= 1'b0;
    end
  end

  assign isIdle        = (state != ST_ACT);
  assign shiftRun      = shiftEn && (state == ST_ACT);
  assign ctl.idle      = isIdle;
  assign ctl.watch     = (state == ST_IDLE);
  assign ctl.leaveIdle = (state == ST_IDLE) && anyHit;

  // R2: accepted request enters Idle next cycle
  p_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!isIdle && idleReq && !shiftEn) |=> isIdle);

  // R3: refused request stays Active and raises the flag
  p_refuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!isIdle && idleReq && shiftEn) |=> (!isIdle && idleErr));

  // R8: wake pulse lasts one cycle
  p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R8: pulse coincides with the first Active cycle after Idle
  p_leave_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!isIdle && $past(isIdle)));

  // R9: the masked first Idle cycle can never produce a wake
  p_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE0) |=> (isIdle && !wakePulse));
endmodule

// File: rtl/ser_idle_wake.sv
module ser_idle_wake
  import ser_wake_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               idleReq,
  input  logic               shiftEn,
  input  logic               wrEn,
  input  logic [2*NCH-1:0]   wrData,
  input  logic [NCH-1:0]     clkIn,
  input  logic [NCH-1:0]     datIn,
  input  logic [NCH-1:0]     clkWakeEn,
  input  logic [NCH-1:0]     datWakeEn,
  input  logic               flagClr,
  output logic               isIdle,
  output logic               shiftRun,
  output logic [2*NCH-1:0]   outSig,
  output logic               wakePulse,
  output logic [NCH-1:0]     wakeSrc,
  output logic               idleErr
);
  ctl_t ctl;
  logic anyHit;

  ser_wake_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .shiftEn(shiftEn),
    .flagClr(flagClr), .anyHit(anyHit), .ctl(ctl), .isIdle(isIdle),
    .shiftRun(shiftRun), .wakePulse(wakePulse), .idleErr(idleErr)
  );

  ser_wake_dp #(.NCH(NCH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEn(wrEn), .wrData(wrData),
    .clkIn(clkIn), .datIn(datIn), .clkWakeEn(clkWakeEn),
    .datWakeEn(datWakeEn), .flagClr(flagClr), .outSig(outSig),
    .wakeSrc(wakeSrc), .anyHit(anyHit)
  );

  // R5: shift engine never permitted while Idle
  p_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |-> !shiftRun);
endmodule

// File: tb/ser_idle_wake_test.sv
module ser_idle_wake_test;
  localparam int NCH = 4;
  localparam int RW  = 2 * NCH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleReq = 0, shiftEn = 0, wrEn = 0, flagClr = 0;
  logic [RW-1:0]  wrData = '0;
  logic [NCH-1:0] clkIn = '1, datIn = '1, clkWakeEn = '0, datWakeEn = '0;
  logic isIdle, shiftRun, wakePulse, idleErr;
  logic [RW-1:0]  outSig;
  logic [NCH-1:0] wakeSrc;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit modelOn = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  ser_idle_wake #(.NCH(NCH)) uut (.*);

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // reference model, built from the requirements
  logic [NCH-1:0] mC1, mC2, mCp, mD1, mD2, mDp, mSrc, mHit;
  logic [RW-1:0]  mOut;
  int             mMode;  // 0 active, 1 first idle, 2 idle
  logic           mPulse, mErr;

  function automatic logic [NCH-1:0] wakeHits(
      input int mode, input logic [NCH-1:0] arm,
      input logic [NCH-1:0] cp, input logic [NCH-1:0] cs,
      input logic [NCH-1:0] dp, input logic [NCH-1:0] ds,
      input logic [NCH-1:0] ce, input logic [NCH-1:0] de);
    if (mode != 2) return '0;
    return arm & ((cp & ~cs & ce) | (dp & ~ds & de));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mC1 <= '1; mC2 <= '1; mCp <= '1;
      mD1 <= '1; mD2 <= '1; mDp <= '1;
      mOut <= '1; mMode <= 0; mPulse <= 0; mErr <= 0; mSrc <= '0;
    end else begin
      mHit = wakeHits(mMode, mOut[NCH-1:0], mCp, mC2, mDp, mD2, clkWakeEn, datWakeEn);
      mC1 <= clkIn; mC2 <= mC1; mCp <= mC2;
      mD1 <= datIn; mD2 <= mD1; mDp <= mD2;
      mPulse <= |mHit;
      mSrc <= (flagClr ? '0 : mSrc) | mHit;
      if (mMode == 0 && idleReq && shiftEn) mErr <= 1'b1;
      else if (flagClr) mErr <= 1'b0;
      if (mMode == 0 && wrEn) mOut <= wrData;
      case (mMode)
        0: if (idleReq && !shiftEn) mMode <= 1;
        1: mMode <= 2;
        default: if (|mHit) mMode <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      chk("R2 R4 R5 R7 R10 random",
          {isIdle, shiftRun, wakePulse, idleErr, wakeSrc, outSig},
          {(mMode != 0), shiftEn && (mMode == 0), mPulse, mErr, mSrc, mOut});
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 isIdle", isIdle, 0);
    chk("R1 outSig", outSig, {RW{1'b1}});
    chk("R1 flags", {wakePulse, idleErr, wakeSrc}, 0);

    // R3 refusal while shift engine on
    shiftEn = 1; idleReq = 1; tick(1); idleReq = 0;
    chk("R3 stays active", isIdle, 0);
    chk("R3 error set", idleErr, 1);
    tick(2);
    chk("R3 error sticky", idleErr, 1);
    flagClr = 1; tick(1); flagClr = 0;
    chk("R3 error cleared", idleErr, 0);

    // R4 write in Active; channels 0 and 2 armed
    wrEn = 1; wrData = {4'hF, 4'b0101}; tick(1); wrEn = 0;
    chk("R4 active write", outSig, {4'hF, 4'b0101});
    chk("R5 shiftRun active", shiftRun, 1);

    // R2 accepted entry
    shiftEn = 0; idleReq = 1; tick(1); idleReq = 0; shiftEn = 1;
    chk("R2 enter idle", isIdle, 1);
    chk("R5 shiftRun idle", shiftRun, 0);
    shiftEn = 0;

    // R4 write ignored in Idle
    wrEn = 1; wrData = '0; tick(1); wrEn = 0;
    chk("R4 idle write ignored", outSig, {4'hF, 4'b0101});
    idleReq = 1; tick(1); idleReq = 0;
    chk("R2 request in idle", isIdle, 1);

    clkWakeEn = '1; datWakeEn = 4'b1011;
    // R6 disarmed channel 1
    clkIn[1] = 0; tick(5);
    chk("R6 disarmed no wake", {isIdle, wakePulse}, 2'b10);
    // R7 rising edge
    clkIn[1] = 1; tick(5);
    chk("R7 rising no wake", {isIdle, wakePulse}, 2'b10);
    // R7 data edge with enable off on armed channel 2
    datIn[2] = 0; tick(5);
    chk("R7 disabled data no wake", {isIdle, wakePulse}, 2'b10);
    datIn[2] = 1; tick(5);

    // R8 timing on clock line of channel 0
    clkIn[0] = 0; tick(2);
    chk("R8 still idle after two edges", isIdle, 1);
    tick(1);
    chk("R8 wake on third edge", {isIdle, wakePulse}, 2'b01);
    chk("R10 source ch0", wakeSrc, 4'b0001);
    tick(1);
    chk("R8 pulse one cycle", wakePulse, 0);
    chk("R10 source held", wakeSrc, 4'b0001);
    clkIn[0] = 1; tick(4);

    // R9 edge landing in first Idle cycle is masked
    clkIn[2] = 0; tick(1);
    idleReq = 1; tick(1); idleReq = 0;
    tick(5);
    chk("R9 masked edge", {isIdle, wakePulse}, 2'b10);
    clkIn[2] = 1; tick(5);
    chk("R7 rising after mask", isIdle, 1);

    // R7 data wake, R10 accumulation
    datWakeEn = '1; datIn[2] = 0; tick(3);
    chk("R7 data wake", {isIdle, wakePulse}, 2'b01);
    chk("R10 accumulate", wakeSrc, 4'b0101);
    datIn[2] = 1;
    flagClr = 1; tick(1); flagClr = 0;
    chk("R10 cleared", wakeSrc, 0);

    // random phase against the model
    rstN = 0; tick(2); rstN = 1; clkWakeEn = '1; datWakeEn = '1;
    modelOn = 1;
    for (int c = 0; c < 4000; c++) begin
      tick(1);
      for (int i = 0; i < NCH; i++) begin
        if ($urandom_range(7) == 0) clkIn[i] = ~clkIn[i];
        if ($urandom_range(7) == 0) datIn[i] = ~datIn[i];
      end
      idleReq = ($urandom_range(9) == 0);
      shiftEn = ($urandom_range(5) == 0);
      wrEn    = ($urandom_range(7) == 0);
      wrData  = RW'($urandom);
      flagClr = ($urandom_range(19) == 0);
      if ($urandom_range(31) == 0) begin
        clkWakeEn = NCH'($urandom);
        datWakeEn = NCH'($urandom);
      end
    end
    tick(1);
    modelOn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule